// File: doc/BRIEF.md
# SAR ADC Conversion Controller

This block sequences a 12-bit successive-approximation converter whose analog multiplexer is shared by eight inputs. Software configures it through a control register on a simple register bus and collects results from a result register. The controller derives a slower converter clock from the bus clock. It presents a channel index and a trial code to an external comparator, and it takes one decision per converter-clock tick, most significant bit first.

A conversion can be started in three ways. Software can start one at once. An edge of one of six external trigger lines can start one, with the edge direction selectable. A burst mode keeps converting every selected channel in ascending order and wraps around from the highest to the lowest. The result register carries the value, the channel it belongs to, a completion flag and an overrun flag. The completion flag clears when software reads the result or writes the control register. The overrun flag marks a burst result that replaced one nobody had read.

Top module: `sar_adc_ctrl_top`

## Requirements
- R1: The control register (word address 0) holds channel mask [7:0], divisor [15:8], burst [16], power-up [21], start code [26:24] and edge polarity [27]. A read returns the written value with every other bit zero. Reset clears it to zero.
- R2: A conversion takes exactly 13 × (divisor + 1) bus-clock cycles. That is one sample tick plus twelve bit ticks, and a tick occurs every divisor + 1 cycles counted from the start.
- R3: When burst is 0, a control write with start code 1 begins a conversion on the lowest selected channel in the same edge. Start code 0 begins nothing. An empty mask begins nothing.
- R4: Start codes 2 to 7 start a conversion on an edge of `extTrig[code-2]` while the controller is idle. Edge bit 1 selects a rising edge and 0 a falling edge. The other edge is ignored.
- R5: Bits are resolved most significant bit first. The first trial after sampling is 0x800. A trial bit is kept when `cmpGe` is high. The published value is the largest code that the comparator reports at or below the input.
- R6: The result register (word address 1) holds the value in [15:4], the channel in [26:24], the overrun flag in [27] and the completion flag in [31]. Every other bit reads zero.
- R7: The completion flag is set when a result is published. It is cleared by a read of the result register or by any control write. When a set and a clear fall in the same cycle, the set wins.
- R8: A control write during a conversion abandons it and starts a new one from the new configuration. The abandoned conversion never publishes.
- R9: With burst set, the start code is ignored. Every selected channel is converted back to back in ascending index order, wrapping from the highest selected channel to the lowest. An empty mask performs no conversion.
- R10: In burst mode, a result that replaces one whose completion flag is still set raises the overrun flag. Reading the result register or writing the control register clears it.
- R11: With power-up at 0, no sampling or trial takes place, and a write that clears power-up abandons a conversion in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Word address: 0 control, 1 result |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid while regRdEn is high |
| extTrig | input | 6 | External trigger lines, synchronous to clk |
| sampleEn | output | 1 | Sample phase of the analog front end |
| chanIdx | output | 3 | Channel routed to the comparator |
| trialCode | output | 12 | Trial value under test, zero outside bit phases |
| cmpGe | input | 1 | Comparator: input is at or above trialCode |

## Verification
The bench builds the block with its default widths: eight channels, a 12-bit result and an 8-bit divisor. A model comparator holds one fixed analog value per channel, including the end codes 0x000 and 0xFFF and the mid-scale pair 0x7FF and 0x800. Divisor values 0 and 3 are used, so the exact completion cycle can be checked one cycle early and on the cycle. Two-channel bursts are let run past unread results, which brings the wrap-around order and the overrun flag within reach.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

  // Control register field positions (software-visible layout)
  localparam int CTL_MASK_LSB  = 0;
  localparam int CTL_DIV_LSB   = 8;
  localparam int CTL_BURST_BIT = 16;
  localparam int CTL_PWR_BIT   = 21;
  localparam int CTL_CODE_LSB  = 24;
  localparam int CTL_EDGE_BIT  = 27;

  // Result register field positions
  localparam int RES_VAL_LSB   = 4;
  localparam int RES_CHAN_LSB  = 24;
  localparam int RES_OVR_BIT   = 27;
  localparam int RES_DONE_BIT  = 31;

  localparam int FIELD_MASK_W  = 8;
  localparam int FIELD_DIV_W   = 8;
  localparam int FIELD_CODE_W  = 3;
  localparam int FIELD_VAL_W   = 12;
  localparam int NUM_TRIG      = (1 << FIELD_CODE_W) - 2;

  localparam logic [FIELD_CODE_W-1:0] CODE_NONE = 3'd0;
  localparam logic [FIELD_CODE_W-1:0] CODE_NOW  = 3'd1;
  localparam logic [FIELD_CODE_W-1:0] CODE_TRIG = 3'd2;

  typedef struct packed {
    logic                      edgeRise;
    logic [FIELD_CODE_W-1:0]   startCode;
    logic                      powerUp;
    logic                      burst;
    logic [FIELD_DIV_W-1:0]    divisor;
    logic [FIELD_MASK_W-1:0]   selMask;
  } convCfg_t;

  typedef struct packed {
    logic clearSar;
    logic stepBit;
    logic publish;
  } convStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2
  } convState_e;

endpackage

// File: rtl/sar_adc_regs.sv
module sar_adc_regs
  import sar_adc_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DIV_W  = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  input  logic [31:0] resultWord,
  output logic [31:0] regRdData,
  output convCfg_t    cfg,
  output convCfg_t    cfgNext,
  output logic        ctrlWr,
  output logic        resRead
);

  localparam logic [FIELD_MASK_W-1:0] MASK_LIMIT = FIELD_MASK_W'((1 << NUM_CH) - 1);
  localparam logic [FIELD_DIV_W-1:0]  DIV_LIMIT  = FIELD_DIV_W'((1 << DIV_W) - 1);

  convCfg_t writeCfg;
  logic     unusedWrBits;

  assign ctrlWr  = regWrEn && (regAddr == 2'd0);
  assign resRead = regRdEn && (regAddr == 2'd1);

  always_comb begin
    writeCfg.selMask   = regWrData[CTL_MASK_LSB +: FIELD_MASK_W] & MASK_LIMIT;
    writeCfg.divisor   = regWrData[CTL_DIV_LSB +: FIELD_DIV_W] & DIV_LIMIT;
    writeCfg.burst     = regWrData[CTL_BURST_BIT];
    writeCfg.powerUp   = regWrData[CTL_PWR_BIT];
    writeCfg.startCode = regWrData[CTL_CODE_LSB +: FIELD_CODE_W];
    writeCfg.edgeRise  = regWrData[CTL_EDGE_BIT];
  end

  assign unusedWrBits = ^{regWrData[31:28], regWrData[23:22], regWrData[20:17]};

  assign cfgNext = ctrlWr ? writeCfg : cfg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfg <= '0;
    else       cfg <= cfgNext;
  end

  function automatic logic [31:0] packCfg(input convCfg_t c);
    logic [31:0] w;
    w = '0;
    w[CTL_MASK_LSB +: FIELD_MASK_W] = c.selMask;
    w[CTL_DIV_LSB +: FIELD_DIV_W]   = c.divisor;
    w[CTL_BURST_BIT]                = c.burst;
    w[CTL_PWR_BIT]                  = c.powerUp;
    w[CTL_CODE_LSB +: FIELD_CODE_W] = c.startCode;
    w[CTL_EDGE_BIT]                 = c.edgeRise;
    return w;
  endfunction

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      case (regAddr)
        2'd0:    regRdData = packCfg(cfg);
        2'd1:    regRdData = resultWord;
        default: regRdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 12,
  parameter int DIV_W  = 8,
  localparam int CH_IDX_W  = $clog2(NUM_CH),
  localparam int BIT_IDX_W = $clog2(RES_W)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  convCfg_t             cfg,
  input  convCfg_t             cfgNext,
  input  logic                 ctrlWr,
  input  logic [NUM_TRIG-1:0]  extTrig,
  output convStrobe_t          strb,
  output logic [BIT_IDX_W-1:0] bitIdx,
  output logic [CH_IDX_W-1:0]  curChan,
  output logic                 sampling,
  output logic                 converting
);

  convState_e           state, nState;
  logic [DIV_W-1:0]     divCnt;
  logic                 tick;
  logic [NUM_TRIG-1:0]  trigPrev;
  logic                 trigHit;
  logic                 startNow;
  logic [CH_IDX_W-1:0]  nChan;
  logic [BIT_IDX_W-1:0] nBit;
  logic [CH_IDX_W:0]    firstNew, firstCur, aboveCur, burstNext;
  logic                 unusedCfg;

  assign unusedCfg = ^{cfg.powerUp, cfgNext.edgeRise, cfgNext.divisor};

  // Lowest selected channel at or above 'from'; MSB set means none found
  function automatic logic [CH_IDX_W:0] pickChan(input logic [FIELD_MASK_W-1:0] mask,
                                                 input logic [CH_IDX_W:0] from);
    logic [CH_IDX_W:0] r;
    r = {1'b1, {CH_IDX_W{1'b0}}};
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask[i] && ((CH_IDX_W+1)'(i) >= from)) r = (CH_IDX_W+1)'(i);
    end
    return r;
  endfunction

  assign firstNew  = pickChan(cfgNext.selMask, '0);
  assign firstCur  = pickChan(cfg.selMask, '0);
  assign aboveCur  = pickChan(cfg.selMask, {1'b0, curChan} + 1'b1);
  assign burstNext = aboveCur[CH_IDX_W] ? firstCur : aboveCur;

  // Converter clock: one tick every divisor+1 bus cycles, phase set at start
  assign tick = (state != ST_IDLE) && (divCnt == cfg.divisor[DIV_W-1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 divCnt <= '0;
    else if (startNow)         divCnt <= '0;
    else if (state != ST_IDLE) divCnt <= tick ? '0 : divCnt + 1'b1;
  end

  // Trigger edge detection on the selected external line
  always_comb begin
    logic cur, old;
    logic [FIELD_CODE_W-1:0] idx;
    idx = cfg.startCode - CODE_TRIG;
    cur = 1'b0;
    old = 1'b0;
    trigHit = 1'b0;
    if (cfg.startCode >= CODE_TRIG) begin
      cur = extTrig[idx];
      old = trigPrev[idx];
      trigHit = cfg.edgeRise ? (cur && !old) : (!cur && old);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trigPrev <= '0;
    else       trigPrev <= extTrig;
  end

  always_comb begin
    nState   = state;
    nChan    = curChan;
    nBit     = bitIdx;
    startNow = 1'b0;
    strb     = '0;
    if (!cfgNext.powerUp) begin
      nState = ST_IDLE;
    end else if (ctrlWr) begin
      if (!firstNew[CH_IDX_W] &&
          (cfgNext.burst || cfgNext.startCode == CODE_NOW || state != ST_IDLE)) begin
        startNow = 1'b1;
        nChan    = firstNew[CH_IDX_W-1:0];
      end else begin
        nState = ST_IDLE;
      end
    end else if (state == ST_IDLE) begin
      if (trigHit && !cfg.burst && !firstCur[CH_IDX_W]) begin
        startNow = 1'b1;
        nChan    = firstCur[CH_IDX_W-1:0];
      end
    end else if (tick) begin
      if (state == ST_SAMPLE) begin
        nState = ST_CONV;
        nBit   = BIT_IDX_W'(RES_W - 1);
      end else begin
        strb.stepBit = 1'b1;
        if (bitIdx == '0) begin
          strb.publish = 1'b1;
          if (cfg.burst && !burstNext[CH_IDX_W]) begin
            startNow = 1'b1;
            nChan    = burstNext[CH_IDX_W-1:0];
          end else begin
            nState = ST_IDLE;
          end
        end else begin
          nBit = bitIdx - 1'b1;
        end
      end
    end
    if (startNow) begin
      nState        = ST_SAMPLE;
      strb.clearSar = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      curChan <= '0;
      bitIdx  <= '0;
    end else begin
      state   <= nState;
      curChan <= nChan;
      bitIdx  <= nBit;
    end
  end

  assign sampling   = (state == ST_SAMPLE);
  assign converting = (state == ST_CONV);

endmodule

// File: rtl/sar_adc_dp.sv
module sar_adc_dp
  import sar_adc_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 12,
  localparam int CH_IDX_W  = $clog2(NUM_CH),
  localparam int BIT_IDX_W = $clog2(RES_W)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  convStrobe_t          strb,
  input  logic [BIT_IDX_W-1:0] bitIdx,
  input  logic [CH_IDX_W-1:0]  curChan,
  input  logic                 converting,
  input  logic                 burst,
  input  logic                 ctrlWr,
  input  logic                 resRead,
  input  logic                 cmpGe,
  output logic [RES_W-1:0]     trialCode,
  output logic [31:0]          resultWord,
  output logic                 doneFlag,
  output logic                 ovrFlag
);

  logic [RES_W-1:0]    sarAcc;
  logic [RES_W-1:0]    keepVal;
  logic [RES_W-1:0]    resVal;
  logic [CH_IDX_W-1:0] resChan;

  assign trialCode = converting ? (sarAcc | (RES_W'(1) << bitIdx)) : '0;
  assign keepVal   = cmpGe ? trialCode : sarAcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             sarAcc <= '0;
    else if (strb.clearSar) sarAcc <= '0;
    else if (strb.stepBit)  sarAcc <= keepVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resVal  <= '0;
      resChan <= '0;
    end else if (strb.publish) begin
      resVal  <= keepVal;
      resChan <= curChan;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
      ovrFlag  <= 1'b0;
    end else if (strb.publish) begin
      doneFlag <= 1'b1;
      if (burst && doneFlag && !resRead) ovrFlag <= 1'b1;
      else if (resRead)                   ovrFlag <= 1'b0;
    end else if (resRead || ctrlWr) begin
      doneFlag <= 1'b0;
      ovrFlag  <= 1'b0;
    end
  end

  always_comb begin
    resultWord = '0;
    resultWord[RES_VAL_LSB +: FIELD_VAL_W] = FIELD_VAL_W'(resVal) << (FIELD_VAL_W - RES_W);
    resultWord[RES_CHAN_LSB +: 3]          = 3'(resChan);
    resultWord[RES_OVR_BIT]                = ovrFlag;
    resultWord[RES_DONE_BIT]               = doneFlag;
  end

endmodule

// File: rtl/sar_adc_ctrl_top.sv
module sar_adc_ctrl_top
  import sar_adc_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 12,
  parameter int DIV_W  = 8,
  localparam int CH_IDX_W  = $clog2(NUM_CH),
  localparam int BIT_IDX_W = $clog2(RES_W)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [1:0]          regAddr,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData,
  input  logic [NUM_TRIG-1:0] extTrig,
  output logic                sampleEn,
  output logic [CH_IDX_W-1:0] chanIdx,
  output logic [RES_W-1:0]    trialCode,
  input  logic                cmpGe
);

  convCfg_t             cfg, cfgNext;
  convStrobe_t          strb;
  logic                 ctrlWr, resRead;
  logic [31:0]          resultWord;
  logic [BIT_IDX_W-1:0] bitIdx;
  logic                 converting;
  logic                 doneFlag, ovrFlag;

  sar_adc_regs #(.NUM_CH(NUM_CH), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .resultWord(resultWord),
    .regRdData(regRdData), .cfg(cfg), .cfgNext(cfgNext),
    .ctrlWr(ctrlWr), .resRead(resRead)
  );

  sar_adc_ctrl #(.NUM_CH(NUM_CH), .RES_W(RES_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfg(cfg), .cfgNext(cfgNext), .ctrlWr(ctrlWr),
    .extTrig(extTrig), .strb(strb), .bitIdx(bitIdx), .curChan(chanIdx),
    .sampling(sampleEn), .converting(converting)
  );

  sar_adc_dp #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bitIdx(bitIdx), .curChan(chanIdx),
    .converting(converting), .burst(cfg.burst), .ctrlWr(ctrlWr),
    .resRead(resRead), .cmpGe(cmpGe), .trialCode(trialCode),
    .resultWord(resultWord), .doneFlag(doneFlag), .ovrFlag(ovrFlag)
  );

endmodule

// File: rtl/sar_adc_chk.sv
module sar_adc_chk #(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 12,
  localparam int CH_IDX_W = $clog2(NUM_CH)
) (
  input logic                clk,
  input logic                rstN,
  input logic                sampleEn,
  input logic [CH_IDX_W-1:0] chanIdx,
  input logic [RES_W-1:0]    trialCode,
  input logic [7:0]          selMask,
  input logic                burst,
  input logic                powerUp,
  input logic                doneFlag,
  input logic                ovrFlag,
  input logic                publish,
  input logic                resRead,
  input logic                ctrlWr
);

  localparam logic [RES_W-1:0] MSB_TRIAL = RES_W'(1) << (RES_W - 1);

  assert_msb_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleEn && $past(sampleEn) && trialCode != '0) |-> (trialCode == MSB_TRIAL));

  assert_idle_when_off_R11: assert property (@(posedge clk) disable iff (!rstN)
    !powerUp |-> (!sampleEn && trialCode == '0));

  assert_chan_selected_R9: assert property (@(posedge clk) disable iff (!rstN)
    sampleEn |-> selMask[chanIdx]);

  assert_done_cleared_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(resRead || ctrlWr) && !$past(publish)) |-> !doneFlag);

  assert_done_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(publish) |-> doneFlag);

  assert_overrun_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrFlag) |-> ($past(burst) && $past(doneFlag)));

endmodule

bind sar_adc_ctrl_top sar_adc_chk #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_chk (
  .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .chanIdx(chanIdx),
  .trialCode(trialCode), .selMask(cfg.selMask), .burst(cfg.burst),
  .powerUp(cfg.powerUp), .doneFlag(doneFlag), .ovrFlag(ovrFlag),
  .publish(strb.publish), .resRead(resRead), .ctrlWr(ctrlWr)
);

// File: tb/sar_adc_ctrl_top_tb.sv
`timescale 1ns/100ps
module sar_adc_ctrl_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [5:0]  extTrig = '0;
  logic        sampleEn;
  logic [2:0]  chanIdx;
  logic [11:0] trialCode;
  logic        cmpGe;
  logic [11:0] anaVal [8];

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign cmpGe = (anaVal[chanIdx] >= trialCode);

  sar_adc_ctrl_top u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .extTrig(extTrig), .sampleEn(sampleEn), .chanIdx(chanIdx),
    .trialCode(trialCode), .cmpGe(cmpGe)
  );

  function automatic logic [31:0] mkCtrl(input logic [7:0] mask, input logic [7:0] dv,
      input logic bst, input logic pwr, input logic [2:0] code, input logic rise);
    return {4'd0, rise, code, 2'd0, pwr, 4'd0, bst, dv, mask};
  endfunction

  function automatic logic [31:0] resWord(input logic dn, input logic ov,
      input logic [2:0] ch, input logic [11:0] v);
    return {dn, 3'd0, ov, ch, 8'd0, v, 4'd0};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // All tasks enter and leave at a falling clock edge
  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCtrl(input logic [31:0] d);
    regWrEn = 1'b1; regAddr = 2'd0; regWrData = d;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] d);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(posedge clk); @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    readReg(2'd0, d); check("R1 reset control", d, 32'h0);
    readReg(2'd1, d); check("R6 reset result", d, 32'h0);
    check("R11 reset idle", {sampleEn, 19'd0, trialCode}, 32'h0);
  endtask

  task automatic testLayout();
    logic [31:0] d;
    writeCtrl(32'hFFDF_FFFF);
    readReg(2'd0, d); check("R1 control readback", d, 32'h0F01_FFFF);
    waitCyc(20);
    check("R11 off no sampling", {31'd0, sampleEn}, 32'h0);
    readReg(2'd1, d); check("R11 off no result", d, 32'h0);
    writeCtrl(mkCtrl(8'h00, 8'd0, 1'b0, 1'b1, 3'd1, 1'b0));
    waitCyc(20);
    readReg(2'd1, d); check("R3 empty mask no start", d, 32'h0);
  endtask

  task automatic testMsbFirst();
    logic [31:0] d;
    writeCtrl(mkCtrl(8'h01, 8'd0, 1'b0, 1'b1, 3'd1, 1'b0));
    check("R3 sampling lowest channel", {sampleEn, 28'd0, chanIdx}, {1'b1, 28'd0, 3'd0});
    waitCyc(1); check("R5 first trial", 32'(trialCode), 32'h800);
    waitCyc(1); check("R5 second trial", 32'(trialCode), 32'hC00);
    waitCyc(11);
    readReg(2'd1, d); check("R5 value ch0", d, resWord(1'b1, 1'b0, 3'd0, 12'hABC));
    readReg(2'd1, d); check("R7 read clears done", d, resWord(1'b0, 1'b0, 3'd0, 12'hABC));
  endtask

  task automatic testDivider();
    logic [31:0] d;
    writeCtrl(mkCtrl(8'h80, 8'd3, 1'b0, 1'b1, 3'd1, 1'b0));
    waitCyc(51);
    readReg(2'd1, d); check("R2 not done one cycle early", {d[31], 31'd0}, 32'h0);
    readReg(2'd1, d); check("R2 done at 13x(div+1)", d, resWord(1'b1, 1'b0, 3'd7, 12'hAAA));
  endtask

  task automatic testEndCodes();
    logic [31:0] d;
    writeCtrl(mkCtrl(8'hA0, 8'd0, 1'b0, 1'b1, 3'd1, 1'b0));
    waitCyc(13);
    readReg(2'd1, d); check("R3 lowest of mask ch5", d, resWord(1'b1, 1'b0, 3'd5, 12'h123));
    writeCtrl(mkCtrl(8'h04, 8'd0, 1'b0, 1'b1, 3'd1, 1'b0));
    waitCyc(13);
    readReg(2'd1, d); check("R5 full scale ch2", d, resWord(1'b1, 1'b0, 3'd2, 12'hFFF));
    writeCtrl(mkCtrl(8'h02, 8'd0, 1'b0, 1'b1, 3'd1, 1'b0));
    waitCyc(13);
    writeCtrl(mkCtrl(8'h02, 8'd0, 1'b0, 1'b1, 3'd0, 1'b0));
    readReg(2'd1, d); check("R7 write clears done", d, resWord(1'b0, 1'b0, 3'd1, 12'h000));
  endtask

  task automatic testRestart();
    logic [31:0] d;
    writeCtrl(mkCtrl(8'h02, 8'd0, 1'b0, 1'b1, 3'd1, 1'b0));
    waitCyc(5);
    writeCtrl(mkCtrl(8'h08, 8'd0, 1'b0, 1'b1, 3'd0, 1'b0));
    waitCyc(12);
    readReg(2'd1, d); check("R8 old conversion dropped", {d[31], 31'd0}, 32'h0);
    readReg(2'd1, d); check("R8 restarted on ch3", d, resWord(1'b1, 1'b0, 3'd3, 12'h800));
  endtask

  task automatic testTrigger();
    logic [31:0] d;
    writeCtrl(mkCtrl(8'h10, 8'd0, 1'b0, 1'b1, 3'd2, 1'b1));
    waitCyc(3);
    check("R4 no start on config", {31'd0, sampleEn}, 32'h0);
    extTrig[0] = 1'b1;
    waitCyc(14);
    readReg(2'd1, d); check("R4 rising edge line 0", d, resWord(1'b1, 1'b0, 3'd4, 12'h7FF));
    extTrig[0] = 1'b0;
    waitCyc(16);
    readReg(2'd1, d); check("R4 falling ignored when rising", {d[31], 31'd0}, 32'h0);
    writeCtrl(mkCtrl(8'h08, 8'd0, 1'b0, 1'b1, 3'd3, 1'b0));
    extTrig[1] = 1'b1;
    waitCyc(15);
    readReg(2'd1, d); check("R4 rising ignored when falling", d, resWord(1'b0, 1'b0, 3'd4, 12'h7FF));
    extTrig[1] = 1'b0;
    waitCyc(14);
    readReg(2'd1, d); check("R4 falling edge line 1", d, resWord(1'b1, 1'b0, 3'd3, 12'h800));
  endtask

  task automatic testBurst();
    logic [31:0] d;
    writeCtrl(mkCtrl(8'h24, 8'd0, 1'b1, 1'b1, 3'd0, 1'b0));
    waitCyc(13);
    readReg(2'd1, d); check("R9 burst first ch2", d, resWord(1'b1, 1'b0, 3'd2, 12'hFFF));
    waitCyc(12);
    readReg(2'd1, d); check("R9 burst ascending ch5", d, resWord(1'b1, 1'b0, 3'd5, 12'h123));
    waitCyc(12);
    readReg(2'd1, d); check("R9 burst wraps to ch2", d, resWord(1'b1, 1'b0, 3'd2, 12'hFFF));
    waitCyc(25);
    readReg(2'd1, d); check("R10 overrun on unread", d, resWord(1'b1, 1'b1, 3'd2, 12'hFFF));
    readReg(2'd1, d); check("R10 read clears overrun", d, resWord(1'b0, 1'b0, 3'd2, 12'hFFF));
    writeCtrl(mkCtrl(8'h00, 8'd0, 1'b1, 1'b1, 3'd1, 1'b0));
    waitCyc(30);
    readReg(2'd1, d); check("R9 burst empty mask idle", {d[31], 30'd0, sampleEn}, 32'h0);
  endtask

  task automatic testPowerDown();
    logic [31:0] d;
    writeCtrl(mkCtrl(8'h40, 8'd0, 1'b0, 1'b1, 3'd1, 1'b0));
    waitCyc(3);
    writeCtrl(mkCtrl(8'h40, 8'd0, 1'b0, 1'b0, 3'd1, 1'b0));
    check("R11 abort stops sampling", {31'd0, sampleEn}, 32'h0);
    waitCyc(15);
    readReg(2'd1, d); check("R11 aborted no publish", {d[31], 31'd0}, 32'h0);
  endtask

  initial begin
    anaVal[0] = 12'hABC; anaVal[1] = 12'h000; anaVal[2] = 12'hFFF; anaVal[3] = 12'h800;
    anaVal[4] = 12'h7FF; anaVal[5] = 12'h123; anaVal[6] = 12'h555; anaVal[7] = 12'hAAA;
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(1);
    testReset();
    testLayout();
    testMsbFirst();
    testDivider();
    testEndCodes();
    testRestart();
    testTrigger();
    testBurst();
    testPowerDown();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule